// File: doc/BRIEF.md
# Multiplexed Asynchronous Bus Master

This block is the master end of a parallel bus whose shared lines carry a 22-bit byte address first and then 16-bit data. A local requester hands it one command at a time. Each command has a direction, a byte-or-word size, a start address, a block length and write data. The master drives an address phase and raises a frame strobe. It then runs one or more data phases. In each data phase it raises a read or write strobe and waits for the slave's reply, with no fixed cycle length.

The master settles the lines before each strobe edge and steers byte data into the lane that address bit 0 picks. It flags I/O-page addresses on a dedicated select line. It limits how long it will wait for any reply edge. The result is reported to the requester as a done pulse or a timeout error pulse. Read words stream out as they arrive. During block writes the master asks for each next write word.

Top module: `mab_master`

## Requirements
- R1: After reset the frame strobe, both data strobes, the line drive enable, the I/O select and the byte flag are low, and `req_ready` is high.
- R2: The address is driven on `bus_dal_out[21:0]` with `bus_dal_oe` high for exactly `SETTLE_CYC` cycles before `bus_sync` rises, and it is still driven in the cycle `bus_sync` rises.
- R3: `bus_iosel` is high during the address phase exactly when address bits 21:13 are all ones, and is low at all other times.
- R4: A word write places the 16-bit word on `bus_dal_out[15:0]` with `bus_wbyte` low, and the slave stores that word at the addressed location.
- R5: A byte write uses one data phase whatever `req_len` says. It drives `bus_wbyte` high and puts the byte on bits 7:0 when address bit 0 is 0, or on bits 15:8 when it is 1. The other lane is zero.
- R6: A byte read returns the lane picked by address bit 0 (bit 0 = 0 gives bits 7:0, 1 gives bits 15:8) in `rd_data[7:0]`, with `rd_data[15:8]` zero.
- R7: A word command with `req_len` = n runs n+1 data phases under a single frame strobe at consecutive word addresses. It yields n+1 `rd_valid` pulses on reads or n+1 `wdata_next` pulses on writes.
- R8: A data strobe drops only after the reply has been seen. No new strobe starts, and the frame strobe does not drop on a completed command, until the reply has gone low again.
- R9: If a reply edge does not arrive within `TIMEOUT_CYC` cycles, the master drops every strobe, pulses `timeout_err` without `done`, and returns to ready.
- R10: `req_ready` is low from acceptance until the command ends. Each completed command gives exactly one `done` pulse, in the cycle after the frame strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Master idle, command accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = single byte transfer |
| req_addr | input | 22 | Start byte address |
| req_len | input | LEN_W | Data phases minus one (word mode) |
| req_wdata | input | 16 | Current write word (byte in bits 7:0) |
| wdata_next | output | 1 | Write word taken; present the next one |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | 16 | Read word, byte-steered |
| done | output | 1 | Command completed pulse |
| timeout_err | output | 1 | Command aborted on timeout pulse |
| bus_dal_out | output | 22 | Shared address/data lines, driven value |
| bus_dal_oe | output | 1 | Drive enable for the shared lines |
| bus_dal_in | input | 22 | Shared lines as seen from the bus |
| bus_sync | output | 1 | Frame strobe |
| bus_din | output | 1 | Read data strobe |
| bus_dout | output | 1 | Write data strobe |
| bus_iosel | output | 1 | I/O page select during address phase |
| bus_wbyte | output | 1 | Byte-size flag during data phases |
| bus_rply | input | 1 | Slave reply |

## Verification
The bench aims at lane steering on odd and even byte addresses. A swapped lane would store or return the wrong half, and a missing zero-fill would leave stale bits in the other lane. It probes the I/O select on both sides of the 8 KB page boundary, where a wrong bit range would flag the neighbouring address. It runs blocks of the full sixteen words: a length off by one would change the slave's phase count and shift the read-back. A silent slave tests the abort path. A broken timeout would hang, or report done instead of an error.

// File: rtl/mab_pkg.sv
package mab_pkg;
    localparam int MAB_AW     = 22;
    localparam int MAB_DW     = 16;
    localparam int MAB_IO_LSB = 13;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AHOLD, ST_DSET, ST_STRB, ST_REL, ST_END, ST_ABORT
    } mab_state_e;

    typedef struct packed {
        logic              write;
        logic              bytem;
        logic [MAB_AW-1:0] addr;
    } mab_cmd_t;

    function automatic logic in_io_page(input logic [MAB_AW-1:0] a);
        return &a[MAB_AW-1:MAB_IO_LSB];
    endfunction
endpackage

// File: rtl/mab_timer.sv
module mab_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    assign hit = en && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en && !hit)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mab_lanes.sv
module mab_lanes
    import mab_pkg::*;
(
    input  logic              bytem,
    input  logic              lane,
    input  logic [MAB_DW-1:0] wr_word,
    input  logic [MAB_DW-1:0] bus_rd,
    output logic [MAB_DW-1:0] bus_wr,
    output logic [MAB_DW-1:0] rd_word
);
    localparam int HB = MAB_DW / 2;

    always_comb begin
        if (!bytem) begin
            bus_wr  = wr_word;
            rd_word = bus_rd;
        end else if (lane) begin
            bus_wr  = {wr_word[HB-1:0], {HB{1'b0}}};
            rd_word = {{HB{1'b0}}, bus_rd[MAB_DW-1:HB]};
        end else begin
            bus_wr  = {{HB{1'b0}}, wr_word[HB-1:0]};
            rd_word = {{HB{1'b0}}, bus_rd[HB-1:0]};
        end
    end
endmodule

// File: rtl/mab_master.sv
module mab_master
    import mab_pkg::*;
#(
    parameter int LEN_W       = 4,
    parameter int SETTLE_CYC  = 2,
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_byte,
    input  logic [MAB_AW-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [MAB_DW-1:0] req_wdata,
    output logic              wdata_next,
    output logic              rd_valid,
    output logic [MAB_DW-1:0] rd_data,
    output logic              done,
    output logic              timeout_err,
    output logic [MAB_AW-1:0] bus_dal_out,
    output logic              bus_dal_oe,
    input  logic [MAB_AW-1:0] bus_dal_in,
    output logic              bus_sync,
    output logic              bus_din,
    output logic              bus_dout,
    output logic              bus_iosel,
    output logic              bus_wbyte,
    input  logic              bus_rply
);
    localparam int PAD_W = MAB_AW - MAB_DW;

    mab_state_e        state_q, state_n;
    mab_cmd_t          cmd_q;
    logic [LEN_W-1:0]  left_q;
    logic [MAB_DW-1:0] data_q;
    logic              s_hit, t_hit, st_chg;
    logic              in_settle, in_wait, addr_ph, data_ph;
    logic [MAB_DW-1:0] steer_wr, steer_rd;

    assign st_chg    = (state_n != state_q);
    assign addr_ph   = (state_q == ST_ADDR) || (state_q == ST_AHOLD);
    assign data_ph   = (state_q == ST_DSET) || (state_q == ST_STRB) || (state_q == ST_REL);
    assign in_settle = addr_ph || (state_q == ST_DSET);
    assign in_wait   = (state_q == ST_STRB) || (state_q == ST_REL);

    mab_timer #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk(clk), .rst(rst), .clr(st_chg), .en(in_settle), .hit(s_hit)
    );

    mab_timer #(.LIMIT(TIMEOUT_CYC)) u_watch (
        .clk(clk), .rst(rst), .clr(st_chg), .en(in_wait), .hit(t_hit)
    );

    mab_lanes u_lanes (
        .bytem  (cmd_q.bytem),
        .lane   (cmd_q.addr[0]),
        .wr_word(req_wdata),
        .bus_rd (bus_dal_in[MAB_DW-1:0]),
        .bus_wr (steer_wr),
        .rd_word(steer_rd)
    );

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_n = ST_ADDR;
            ST_ADDR:  if (s_hit) state_n = ST_AHOLD;
            ST_AHOLD: if (s_hit) state_n = ST_DSET;
            ST_DSET:  if (s_hit) state_n = ST_STRB;
            ST_STRB:  if (bus_rply) state_n = ST_REL;
                      else if (t_hit) state_n = ST_ABORT;
            ST_REL:   if (!bus_rply) state_n = (left_q == '0) ? ST_END : ST_DSET;
                      else if (t_hit) state_n = ST_ABORT;
            ST_END:   state_n = ST_IDLE;
            ST_ABORT: state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cmd_q       <= '0;
            left_q      <= '0;
            data_q      <= '0;
            wdata_next  <= 1'b0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            done        <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            state_q     <= state_n;
            wdata_next  <= 1'b0;
            rd_valid    <= 1'b0;
            done        <= (state_q == ST_END);
            timeout_err <= (state_q == ST_ABORT);
            if (state_q == ST_IDLE && req_valid) begin
                cmd_q.write <= req_write;
                cmd_q.bytem <= req_byte;
                cmd_q.addr  <= req_addr;
                left_q      <= req_byte ? '0 : req_len;
            end
            if (state_n == ST_DSET && st_chg) begin
                data_q     <= steer_wr;
                wdata_next <= cmd_q.write;
            end
            if (state_q == ST_REL && state_n == ST_DSET)
                left_q <= left_q - 1'b1;
            if (state_q == ST_STRB && bus_rply && !cmd_q.write) begin
                rd_data  <= steer_rd;
                rd_valid <= 1'b1;
            end
        end
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign bus_sync    = (state_q == ST_AHOLD) || data_ph;
    assign bus_din     = (state_q == ST_STRB) && !cmd_q.write;
    assign bus_dout    = (state_q == ST_STRB) && cmd_q.write;
    assign bus_dal_oe  = addr_ph || (data_ph && cmd_q.write);
    assign bus_dal_out = addr_ph ? cmd_q.addr : {{PAD_W{1'b0}}, data_q};
    assign bus_iosel   = addr_ph && in_io_page(cmd_q.addr);
    assign bus_wbyte   = data_ph && cmd_q.bytem;
endmodule

// File: rtl/mab_master_chk.sv
module mab_master_chk
    import mab_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              done,
    input logic              timeout_err,
    input logic              rd_valid,
    input logic [MAB_AW-1:0] bus_dal_out,
    input logic              bus_dal_oe,
    input logic              bus_sync,
    input logic              bus_din,
    input logic              bus_dout,
    input logic              bus_iosel,
    input logic              bus_rply
);
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(bus_din && bus_dout));

    p_strobe_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_din || bus_dout) |-> bus_sync);

    p_sync_rise_addr_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_sync) |-> (bus_dal_oe && $stable(bus_dal_out)));

    p_iosel_driven_r3: assert property (@(posedge clk) disable iff (rst)
        bus_iosel |-> (bus_dal_oe && !bus_din && !bus_dout));

    p_din_release_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_din) && bus_sync) |-> $past(bus_rply));

    p_dout_release_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_dout) && bus_sync) |-> $past(bus_rply));

    p_write_drives_r4: assert property (@(posedge clk) disable iff (rst)
        bus_dout |-> bus_dal_oe);

    p_end_report_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_sync) |=> (done || timeout_err));

    p_done_err_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout_err));

    p_ready_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!bus_sync && !bus_dal_oe && !rd_valid));
endmodule

bind mab_master mab_master_chk u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .done(done),
    .timeout_err(timeout_err), .rd_valid(rd_valid),
    .bus_dal_out(bus_dal_out), .bus_dal_oe(bus_dal_oe), .bus_sync(bus_sync),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_iosel(bus_iosel),
    .bus_rply(bus_rply)
);

// File: tb/sim_mab_master.sv
module sim_mab_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
    logic [21:0] req_addr = '0;
    logic [3:0]  req_len = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, wdata_next, rd_valid, done, timeout_err;
    logic [15:0] rd_data;
    logic [21:0] bus_dal_out;
    logic [21:0] bus_dal_in = '0;
    logic        bus_dal_oe, bus_sync, bus_din, bus_dout, bus_iosel, bus_wbyte;
    logic        bus_rply = 1'b0;

    always #4 clk = ~clk;

    mab_master u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_byte(req_byte), .req_addr(req_addr),
        .req_len(req_len), .req_wdata(req_wdata), .wdata_next(wdata_next),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
        .timeout_err(timeout_err), .bus_dal_out(bus_dal_out),
        .bus_dal_oe(bus_dal_oe), .bus_dal_in(bus_dal_in), .bus_sync(bus_sync),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_iosel(bus_iosel),
        .bus_wbyte(bus_wbyte), .bus_rply(bus_rply)
    );

    int errors = 0, checks = 0;
    logic finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Slave model and bus monitors
    logic [15:0] s_mem [256];
    logic [15:0] ref_mem [256];
    logic [21:0] s_addr = '0, s_first = '0;
    logic        s_io = 1'b0, s_mute = 1'b0, s_wbyte = 1'b0;
    logic [15:0] s_lastwr = '0;
    int          s_phases = 0, s_pre = 0, pre_cnt = 0, s_cnt = 0, s_st = 0;
    int          viol = 0;
    logic        sync_d = 1'b0, strb_d = 1'b0, rply_d = 1'b0;

    function automatic logic [15:0] seed_word(input int i);
        return 16'(i * 16'h1357) ^ 16'hA5C3;
    endfunction

    always @(posedge clk) begin
        sync_d <= bus_sync;
        strb_d <= bus_din || bus_dout;
        rply_d <= bus_rply;
        if (bus_dal_oe && !bus_sync) pre_cnt <= pre_cnt + 1;
        else if (!bus_dal_oe) pre_cnt <= 0;
        if (!s_mute && !rst) begin
            if (strb_d && !(bus_din || bus_dout) && bus_sync && !rply_d) viol <= viol + 1;
            if (!strb_d && (bus_din || bus_dout) && bus_rply) viol <= viol + 1;
            if (sync_d && !bus_sync && bus_rply) viol <= viol + 1;
        end
        if (bus_sync && !sync_d) begin
            s_addr   <= bus_dal_out;
            s_first  <= bus_dal_out;
            s_io     <= bus_iosel;
            s_pre    <= pre_cnt;
            s_phases <= 0;
        end
        if (s_cnt > 0) s_cnt <= s_cnt - 1;
        case (s_st)
            0: if ((bus_din || bus_dout) && !s_mute) begin
                   s_cnt <= int'($urandom % 4); s_st <= 1;
               end
            1: if (s_cnt == 0) begin
                   if (bus_din) bus_dal_in <= {6'b0, s_mem[s_addr[8:1]]};
                   if (bus_dout) begin
                       s_lastwr <= bus_dal_out[15:0];
                       s_wbyte  <= bus_wbyte;
                       if (!bus_wbyte) s_mem[s_addr[8:1]] <= bus_dal_out[15:0];
                       else if (s_addr[0]) s_mem[s_addr[8:1]][15:8] <= bus_dal_out[15:8];
                       else s_mem[s_addr[8:1]][7:0] <= bus_dal_out[7:0];
                   end
                   bus_rply <= 1'b1; s_st <= 2;
               end
            2: if (!bus_din && !bus_dout) begin
                   s_cnt <= int'($urandom % 4); s_st <= 3;
               end
            default: if (s_cnt == 0) begin
                   bus_rply <= 1'b0; s_addr <= s_addr + 22'd2;
                   s_phases <= s_phases + 1; s_st <= 0;
               end
        endcase
    end

    logic [15:0] wbuf [16];
    logic [15:0] rbuf [16];
    int nrd, npop, busy_viol;
    bit got_done, got_err;

    task automatic run(input bit w, input bit b, input logic [21:0] a, input logic [3:0] len);
        int guard;
        nrd = 0; npop = 0; busy_viol = 0; got_done = 0; got_err = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_byte = b; req_addr = a;
        req_len = len; req_wdata = wbuf[0];
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!got_done && !got_err && guard < 5000) begin
            if (rd_valid && nrd < 16) begin rbuf[nrd] = rd_data; nrd++; end
            if (wdata_next) begin npop++; req_wdata = wbuf[npop % 16]; end
            if (done) got_done = 1;
            if (timeout_err) got_err = 1;
            if (req_ready && !done && !timeout_err) busy_viol++;
            guard++;
            @(negedge clk);
        end
    endtask

    task automatic txn_check(input bit w, input bit b, input logic [21:0] a, input logic [3:0] len);
        int n;
        logic [7:0] idx;
        logic [15:0] exp;
        n = b ? 1 : int'(len) + 1;
        run(w, b, a, len);
        chk(got_done && !got_err, "R10 done pulse", int'(got_done), 1);
        chk(busy_viol == 0, "R10 ready low while busy", busy_viol, 0);
        chk(s_first == a, "R2 address at frame start", int'(s_first), int'(a));
        chk(s_pre == 2, "R2 settle before frame", s_pre, 2);
        chk(s_io == (&a[21:13]), "R3 io select", int'(s_io), int'(&a[21:13]));
        chk(s_phases == n, b ? "R5 byte single phase" : "R7 phase count", s_phases, n);
        if (w) begin
            chk(npop == n, "R7 write word requests", npop, n);
            for (int k = 0; k < n; k++) begin
                idx = 8'(a[8:1] + 8'(k));
                if (!b) ref_mem[idx] = wbuf[k];
                else if (a[0]) ref_mem[idx][15:8] = wbuf[0][7:0];
                else ref_mem[idx][7:0] = wbuf[0][7:0];
            end
            if (b) begin
                exp = a[0] ? {wbuf[0][7:0], 8'h00} : {8'h00, wbuf[0][7:0]};
                chk(s_lastwr == exp && s_wbyte, "R5 byte lane on bus", int'(s_lastwr), int'(exp));
            end else begin
                chk(!s_wbyte, "R4 word flag low", int'(s_wbyte), 0);
            end
        end else begin
            chk(nrd == n, "R7 read word count", nrd, n);
            for (int k = 0; k < n && k < nrd; k++) begin
                idx = 8'(a[8:1] + 8'(k));
                if (!b) exp = ref_mem[idx];
                else exp = {8'h00, a[0] ? ref_mem[idx][15:8] : ref_mem[idx][7:0]};
                chk(rbuf[k] == exp, b ? "R6 byte read lane" : "R7 read data", int'(rbuf[k]), int'(exp));
            end
        end
    endtask

    initial begin
        void'($urandom(32'd11));
        for (int i = 0; i < 256; i++) begin
            s_mem[i] = seed_word(i);
            ref_mem[i] = seed_word(i);
        end
        for (int i = 0; i < 16; i++) wbuf[i] = 16'h0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!bus_sync && !bus_din && !bus_dout && !bus_dal_oe && !bus_iosel && !bus_wbyte,
            "R1 bus idle in reset", int'({bus_sync, bus_din, bus_dout, bus_dal_oe, bus_iosel}), 0);
        chk(req_ready, "R1 ready in reset", int'(req_ready), 1);
        rst = 1'b0;
        @(negedge clk);

        // R4 word write then read back
        wbuf[0] = 16'hBEEF;
        txn_check(1, 0, 22'h000010, 4'd0);
        txn_check(0, 0, 22'h000010, 4'd0);
        // R5 byte writes on both lanes, with a nonzero length that must be ignored
        wbuf[0] = 16'h7712;
        txn_check(1, 1, 22'h000021, 4'd5);
        wbuf[0] = 16'h3356;
        txn_check(1, 1, 22'h000040, 4'd9);
        // R6 byte reads on both lanes
        txn_check(0, 1, 22'h000021, 4'd0);
        txn_check(0, 1, 22'h000040, 4'd3);
        txn_check(0, 0, 22'h000020, 4'd0);
        // R7 full-length block write and read
        for (int i = 0; i < 16; i++) wbuf[i] = 16'(16'h1100 + i * 16'h0101);
        txn_check(1, 0, 22'h000080, 4'd15);
        txn_check(0, 0, 22'h000080, 4'd15);
        // R3 I/O page boundary
        txn_check(0, 0, 22'h3FE000, 4'd0);
        txn_check(0, 0, 22'h3FDFFE, 4'd1);

        // R9 timeout with a silent slave
        s_mute = 1'b1;
        run(0, 0, 22'h000100, 4'd0);
        chk(got_err && !got_done, "R9 timeout error not done", int'({got_err, got_done}), 2);
        chk(!bus_sync && !bus_din && !bus_dout && req_ready, "R9 strobes dropped",
            int'({bus_sync, bus_din, bus_dout, req_ready}), 1);
        s_mute = 1'b0;
        @(negedge clk);

        // Random mix
        for (int t = 0; t < 60; t++) begin
            bit w, b;
            logic [21:0] a;
            logic [3:0] len;
            w = 1'($urandom);
            b = ($urandom % 4) == 0;
            a = 22'($urandom);
            if (($urandom % 4) == 0) a[21:13] = 9'h1FF;
            if (!b) a[0] = 1'b0;
            len = 4'($urandom);
            for (int i = 0; i < 16; i++) wbuf[i] = 16'($urandom);
            txn_check(w, b, a, len);
        end
        // R8 handshake order over the whole run
        chk(viol == 0, "R8 handshake order", viol, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule